// File: doc/BRIEF.md
# Guest Control Register Entry Checker

This block decides whether a proposed set of guest control-register values may be loaded when a virtual machine is entered. It takes the guest values of control registers 0, 3 and 4 and the debug-control register. It also takes the capability masks that say which control-register bits are forced to one or forced to zero, a mask of reserved debug-control bits, a physical-address width, and four mode controls. From these it produces a pass bit and a vector with one bit per rule that was broken.

A one-cycle start pulse captures every input. On the following clock edge the verdict is registered, and `done` pulses for one cycle. The verdict stays on the outputs until the next verdict replaces it. Starts may come on consecutive cycles, and each one yields its own `done` pulse in order.

Top module: `gcr_entry_checker`

## Requirements
- R1: A start sampled high at clock edge N makes `done` high for the cycle after edge N+1. The verdict from that start appears at edge N+1 and is held until the next verdict. Back-to-back starts give back-to-back `done` pulses.
- R2: `pass` is 1 exactly when every bit of `failVec` is 0. Bit map of `failVec`: 0 CR0 forced-bit rule, 1 paging-without-protection, 2 CR4 forced-bit rule, 3 debug reserved bits, 4 64-bit guest prerequisites, 5 process-context-ID outside 64-bit mode, 6 CR3 upper address bits.
- R3: `failVec[0]` is set when a CR0 bit is 0 where `cr0Fixed0` has a 1, or is 1 where `cr0Fixed1` has a 0. CR0 bits 29 and 30 are never compared.
- R4: When `unrestrictedGuest` and `secondaryCtlEn` are both 1, CR0 bits 0 and 31 are left out of the R3 comparison. If either input is 0, those bits are compared.
- R5: `failVec[1]` is set when CR0 bit 31 is 1 and CR0 bit 0 is 0. This applies in every mode.
- R6: `failVec[2]` is set when a CR4 bit breaks `cr4Fixed0` or `cr4Fixed1` in the same sense as R3. No CR4 bit is exempt.
- R7: With `loadDbgCtl` 1, `failVec[3]` is set when any bit set in `dbgRsvdMask` is also set in `dbgCtlVal`. With `loadDbgCtl` 0, this bit is always 0.
- R8: With `longModeGuest` 1, `failVec[4]` is set unless both CR0 bit 31 and CR4 bit 5 are 1.
- R9: With `longModeGuest` 0, `failVec[5]` is set when CR4 bit 17 is 1.
- R10: `failVec[6]` is set when any CR3 bit from the effective width up to bit 63 is 1. The effective width is `physAddrWidth` clamped to the range 32..52.
- R11: During and straight after reset, `done` is 0, `failVec` is 0 and `pass` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Capture inputs and evaluate |
| cr0Val | input | 64 | Proposed guest CR0 |
| cr3Val | input | 64 | Proposed guest CR3 |
| cr4Val | input | 64 | Proposed guest CR4 |
| dbgCtlVal | input | 64 | Proposed guest debug-control value |
| cr0Fixed0 | input | 64 | CR0 bits that must be 1 |
| cr0Fixed1 | input | 64 | CR0 bits allowed to be 1 |
| cr4Fixed0 | input | 64 | CR4 bits that must be 1 |
| cr4Fixed1 | input | 64 | CR4 bits allowed to be 1 |
| dbgRsvdMask | input | 64 | Reserved debug-control bits |
| physAddrWidth | input | 8 | Physical-address width in bits |
| unrestrictedGuest | input | 1 | Unrestricted guest control |
| secondaryCtlEn | input | 1 | Enables the secondary controls |
| loadDbgCtl | input | 1 | Debug control is loaded on entry |
| longModeGuest | input | 1 | Guest enters in 64-bit mode |
| done | output | 1 | One-cycle verdict strobe |
| pass | output | 1 | No rule broken |
| failVec | output | 7 | Per-rule failure bits |

## Verification
The hardest case to reach from the ports is a guest that drops both the protection and paging bits of CR0 while the forced-one mask demands them. This is only legal when the unrestricted control and its enable are both set. The stimulus runs the same register image three times: with both enables set, with only the unrestricted control set, and with paging set but protection cleared. It keeps the 64-bit mode and CR4 setup neutral, so the exemption, its gating and the paging-without-protection rule are seen apart from each other. CR3 width clamping is reached by driving widths below 32 and above 52, with single-bit addresses placed just either side of each bound.

// File: rtl/gcr_pkg.sv
package gcr_pkg;
  localparam int NUM_RULES = 7;

  localparam int RULE_CR0_FIXED = 0;
  localparam int RULE_PG_NO_PE  = 1;
  localparam int RULE_CR4_FIXED = 2;
  localparam int RULE_DBG_RSVD  = 3;
  localparam int RULE_LONG_REQ  = 4;
  localparam int RULE_PCID      = 5;
  localparam int RULE_CR3_HIGH  = 6;

  localparam int CR0_PE_BIT  = 0;
  localparam int CR0_NW_BIT  = 29;
  localparam int CR0_CD_BIT  = 30;
  localparam int CR0_PG_BIT  = 31;
  localparam int CR4_PAE_BIT = 5;
  localparam int CR4_PCID_BIT = 17;

  typedef struct packed {
    logic capture;
    logic commit;
  } gcr_strobe_t;
endpackage

// File: rtl/gcr_fixed_check.sv
module gcr_fixed_check #(
  parameter int W = 64
) (
  input  logic [W-1:0] value,
  input  logic [W-1:0] mustBeOne,
  input  logic [W-1:0] mayBeOne,
  input  logic [W-1:0] skipMask,
  output logic         violation
);
  logic [W-1:0] bitBad;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign bitBad[i] = !skipMask[i] &&
                       ((mustBeOne[i] && !value[i]) || (!mayBeOne[i] && value[i]));
  end

  assign violation = |bitBad;
endmodule

// File: rtl/gcr_ctrl.sv
module gcr_ctrl
  import gcr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  output gcr_strobe_t strobe,
  output logic        done
);
  logic startQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startQ <= 1'b0;
      done   <= 1'b0;
    end else begin
      startQ <= start;
      done   <= startQ;
    end
  end

  assign strobe.capture = start;
  assign strobe.commit  = startQ;
endmodule

// File: rtl/gcr_datapath.sv
module gcr_datapath
  import gcr_pkg::*;
#(
  parameter int XLEN     = 64,
  parameter int PAW_W    = 8,
  parameter int PAW_MIN  = 32,
  parameter int PAW_MAX  = 52,
  parameter int ADDR_CAP = 52
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  gcr_strobe_t          strobe,
  input  logic [XLEN-1:0]      cr0Val,
  input  logic [XLEN-1:0]      cr3Val,
  input  logic [XLEN-1:0]      cr4Val,
  input  logic [XLEN-1:0]      dbgCtlVal,
  input  logic [XLEN-1:0]      cr0Fixed0,
  input  logic [XLEN-1:0]      cr0Fixed1,
  input  logic [XLEN-1:0]      cr4Fixed0,
  input  logic [XLEN-1:0]      cr4Fixed1,
  input  logic [XLEN-1:0]      dbgRsvdMask,
  input  logic [PAW_W-1:0]     physAddrWidth,
  input  logic                 unrestrictedGuest,
  input  logic                 secondaryCtlEn,
  input  logic                 loadDbgCtl,
  input  logic                 longModeGuest,
  output logic [NUM_RULES-1:0] failVec,
  output logic                 pass
);
  logic [XLEN-1:0]  cr0Q, cr3Q, cr4Q, dbgQ;
  logic [XLEN-1:0]  cr0F0Q, cr0F1Q, cr4F0Q, cr4F1Q, rsvdQ;
  logic [PAW_W-1:0] pawQ;
  logic             ugQ, secQ, ldQ, lmQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cr0Q   <= '0;
      cr3Q   <= '0;
      cr4Q   <= '0;
      dbgQ   <= '0;
      cr0F0Q <= '0;
      cr0F1Q <= '0;
      cr4F0Q <= '0;
      cr4F1Q <= '0;
      rsvdQ  <= '0;
      pawQ   <= '0;
      ugQ    <= 1'b0;
      secQ   <= 1'b0;
      ldQ    <= 1'b0;
      lmQ    <= 1'b0;
    end else if (strobe.capture) begin
      cr0Q   <= cr0Val;
      cr3Q   <= cr3Val;
      cr4Q   <= cr4Val;
      dbgQ   <= dbgCtlVal;
      cr0F0Q <= cr0Fixed0;
      cr0F1Q <= cr0Fixed1;
      cr4F0Q <= cr4Fixed0;
      cr4F1Q <= cr4Fixed1;
      rsvdQ  <= dbgRsvdMask;
      pawQ   <= physAddrWidth;
      ugQ    <= unrestrictedGuest;
      secQ   <= secondaryCtlEn;
      ldQ    <= loadDbgCtl;
      lmQ    <= longModeGuest;
    end
  end

  // Effective unrestricted mode needs its enabling control.
  logic ugEff;
  assign ugEff = ugQ & secQ;

  logic [XLEN-1:0] cr0Skip;
  always_comb begin
    cr0Skip              = '0;
    cr0Skip[CR0_NW_BIT]  = 1'b1;
    cr0Skip[CR0_CD_BIT]  = 1'b1;
    cr0Skip[CR0_PE_BIT]  = ugEff;
    cr0Skip[CR0_PG_BIT]  = ugEff;
  end

  logic cr0Bad, cr4Bad;

  gcr_fixed_check #(.W(XLEN)) cr0Chk_i (
    .value     (cr0Q),
    .mustBeOne (cr0F0Q),
    .mayBeOne  (cr0F1Q),
    .skipMask  (cr0Skip),
    .violation (cr0Bad)
  );

  gcr_fixed_check #(.W(XLEN)) cr4Chk_i (
    .value     (cr4Q),
    .mustBeOne (cr4F0Q),
    .mayBeOne  (cr4F1Q),
    .skipMask  ('0),
    .violation (cr4Bad)
  );

  // Clamp the address width to the supported window.
  logic [PAW_W-1:0] pawClamp;
  always_comb begin
    if (pawQ < PAW_W'(PAW_MIN))      pawClamp = PAW_W'(PAW_MIN);
    else if (pawQ > PAW_W'(PAW_MAX)) pawClamp = PAW_W'(PAW_MAX);
    else                             pawClamp = pawQ;
  end

  logic [XLEN-1:0] cr3Allowed;
  for (genvar i = 0; i < XLEN; i++) begin : g_cr3
    assign cr3Allowed[i] = (i < ADDR_CAP) && (i < int'(pawClamp));
  end

  logic [NUM_RULES-1:0] ruleVec;
  always_comb begin
    ruleVec                 = '0;
    ruleVec[RULE_CR0_FIXED] = cr0Bad;
    ruleVec[RULE_PG_NO_PE]  = cr0Q[CR0_PG_BIT] & ~cr0Q[CR0_PE_BIT];
    ruleVec[RULE_CR4_FIXED] = cr4Bad;
    ruleVec[RULE_DBG_RSVD]  = ldQ & (|(dbgQ & rsvdQ));
    ruleVec[RULE_LONG_REQ]  = lmQ & ~(cr0Q[CR0_PG_BIT] & cr4Q[CR4_PAE_BIT]);
    ruleVec[RULE_PCID]      = ~lmQ & cr4Q[CR4_PCID_BIT];
    ruleVec[RULE_CR3_HIGH]  = |(cr3Q & ~cr3Allowed);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      failVec <= '0;
      pass    <= 1'b1;
    end else if (strobe.commit) begin
      failVec <= ruleVec;
      pass    <= ~(|ruleVec);
    end
  end
endmodule

// File: rtl/gcr_entry_checker.sv
module gcr_entry_checker
  import gcr_pkg::*;
#(
  parameter int XLEN     = 64,
  parameter int PAW_W    = 8,
  parameter int PAW_MIN  = 32,
  parameter int PAW_MAX  = 52,
  parameter int ADDR_CAP = 52
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 start,
  input  logic [XLEN-1:0]      cr0Val,
  input  logic [XLEN-1:0]      cr3Val,
  input  logic [XLEN-1:0]      cr4Val,
  input  logic [XLEN-1:0]      dbgCtlVal,
  input  logic [XLEN-1:0]      cr0Fixed0,
  input  logic [XLEN-1:0]      cr0Fixed1,
  input  logic [XLEN-1:0]      cr4Fixed0,
  input  logic [XLEN-1:0]      cr4Fixed1,
  input  logic [XLEN-1:0]      dbgRsvdMask,
  input  logic [PAW_W-1:0]     physAddrWidth,
  input  logic                 unrestrictedGuest,
  input  logic                 secondaryCtlEn,
  input  logic                 loadDbgCtl,
  input  logic                 longModeGuest,
  output logic                 done,
  output logic                 pass,
  output logic [NUM_RULES-1:0] failVec
);
  gcr_strobe_t strobe;

  gcr_ctrl ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .strobe (strobe),
    .done   (done)
  );

  gcr_datapath #(
    .XLEN(XLEN), .PAW_W(PAW_W), .PAW_MIN(PAW_MIN),
    .PAW_MAX(PAW_MAX), .ADDR_CAP(ADDR_CAP)
  ) dp_i (
    .clk               (clk),
    .rstN              (rstN),
    .strobe            (strobe),
    .cr0Val            (cr0Val),
    .cr3Val            (cr3Val),
    .cr4Val            (cr4Val),
    .dbgCtlVal         (dbgCtlVal),
    .cr0Fixed0         (cr0Fixed0),
    .cr0Fixed1         (cr0Fixed1),
    .cr4Fixed0         (cr4Fixed0),
    .cr4Fixed1         (cr4Fixed1),
    .dbgRsvdMask       (dbgRsvdMask),
    .physAddrWidth     (physAddrWidth),
    .unrestrictedGuest (unrestrictedGuest),
    .secondaryCtlEn    (secondaryCtlEn),
    .loadDbgCtl        (loadDbgCtl),
    .longModeGuest     (longModeGuest),
    .failVec           (failVec),
    .pass              (pass)
  );
endmodule

// File: rtl/gcr_entry_checker_chk.sv
module gcr_entry_checker_chk #(
  parameter int HIGH_W = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              done,
  input logic              pass,
  input logic [6:0]        failVec,
  input logic              pgBit,
  input logic              peBit,
  input logic              paeBit,
  input logic              pcidBit,
  input logic [HIGH_W-1:0] cr3High,
  input logic              loadDbgCtl,
  input logic              longModeGuest
);
  assert_done_after_start_R1: assert property (@(posedge clk) disable iff (!rstN)
    start |=> ##1 done);

  assert_done_has_cause_R1: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(start, 2));

  assert_pass_matches_vec_R2: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (pass == (failVec == 7'd0)));

  assert_pg_without_pe_R5: assert property (@(posedge clk) disable iff (!rstN)
    (done && $past(pgBit, 2) && !$past(peBit, 2)) |-> failVec[1]);

  assert_dbg_skipped_R7: assert property (@(posedge clk) disable iff (!rstN)
    (done && !$past(loadDbgCtl, 2)) |-> !failVec[3]);

  assert_long_needs_pae_R8: assert property (@(posedge clk) disable iff (!rstN)
    (done && $past(longModeGuest, 2) && !$past(paeBit, 2)) |-> failVec[4]);

  assert_pcid_outside_long_R9: assert property (@(posedge clk) disable iff (!rstN)
    (done && !$past(longModeGuest, 2) && $past(pcidBit, 2)) |-> failVec[5]);

  assert_cr3_top_bits_R10: assert property (@(posedge clk) disable iff (!rstN)
    (done && ($past(cr3High, 2) != '0)) |-> failVec[6]);
endmodule

bind gcr_entry_checker gcr_entry_checker_chk #(.HIGH_W(XLEN - ADDR_CAP)) chk_i (
  .clk           (clk),
  .rstN          (rstN),
  .start         (start),
  .done          (done),
  .pass          (pass),
  .failVec       (failVec),
  .pgBit         (cr0Val[31]),
  .peBit         (cr0Val[0]),
  .paeBit        (cr4Val[5]),
  .pcidBit       (cr4Val[17]),
  .cr3High       (cr3Val[XLEN-1:ADDR_CAP]),
  .loadDbgCtl    (loadDbgCtl),
  .longModeGuest (longModeGuest)
);

// File: tb/gcr_entry_checker_tb_top.sv
`timescale 1ns/1ps
module gcr_entry_checker_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [63:0] cr0Val, cr3Val, cr4Val, dbgCtlVal;
  logic [63:0] cr0Fixed0, cr0Fixed1, cr4Fixed0, cr4Fixed1, dbgRsvdMask;
  logic [7:0]  physAddrWidth;
  logic unrestrictedGuest, secondaryCtlEn, loadDbgCtl, longModeGuest;
  logic done, pass;
  logic [6:0] failVec;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  gcr_entry_checker dut_i (
    .clk(clk), .rstN(rstN), .start(start),
    .cr0Val(cr0Val), .cr3Val(cr3Val), .cr4Val(cr4Val), .dbgCtlVal(dbgCtlVal),
    .cr0Fixed0(cr0Fixed0), .cr0Fixed1(cr0Fixed1),
    .cr4Fixed0(cr4Fixed0), .cr4Fixed1(cr4Fixed1),
    .dbgRsvdMask(dbgRsvdMask), .physAddrWidth(physAddrWidth),
    .unrestrictedGuest(unrestrictedGuest), .secondaryCtlEn(secondaryCtlEn),
    .loadDbgCtl(loadDbgCtl), .longModeGuest(longModeGuest),
    .done(done), .pass(pass), .failVec(failVec)
  );

  // Behavioural reference of the rule set.
  function automatic logic [6:0] refModel();
    logic [6:0] v = '0;
    bit ugEff = unrestrictedGuest && secondaryCtlEn;
    int w;
    for (int b = 0; b < 64; b++) begin
      if (b == 29 || b == 30) continue;
      if (ugEff && (b == 0 || b == 31)) continue;
      if (cr0Fixed0[b] && !cr0Val[b]) v[0] = 1'b1;
      if (!cr0Fixed1[b] && cr0Val[b]) v[0] = 1'b1;
    end
    if (cr0Val[31] && !cr0Val[0]) v[1] = 1'b1;
    for (int b = 0; b < 64; b++) begin
      if (cr4Fixed0[b] && !cr4Val[b]) v[2] = 1'b1;
      if (!cr4Fixed1[b] && cr4Val[b]) v[2] = 1'b1;
    end
    if (loadDbgCtl && ((dbgCtlVal & dbgRsvdMask) != 64'd0)) v[3] = 1'b1;
    if (longModeGuest && !(cr0Val[31] && cr4Val[5])) v[4] = 1'b1;
    if (!longModeGuest && cr4Val[17]) v[5] = 1'b1;
    w = int'(physAddrWidth);
    if (w < 32) w = 32;
    if (w > 52) w = 52;
    for (int b = w; b < 64; b++) if (cr3Val[b]) v[6] = 1'b1;
    return v;
  endfunction

  // Cycle model: queue of verdicts with the cycle they are due.
  logic [6:0] vecQ[$];
  int         dueQ[$];
  int         cyc = 0;
  bit         expDone = 1'b0;
  logic [6:0] expVec = '0;

  always @(posedge clk) begin
    if (!rstN) begin
      vecQ.delete();
      dueQ.delete();
      expDone = 1'b0;
      expVec  = '0;
    end else begin
      if (dueQ.size() > 0 && dueQ[0] == cyc) begin
        expDone = 1'b1;
        expVec  = vecQ.pop_front();
        void'(dueQ.pop_front());
      end else begin
        expDone = 1'b0;
      end
      if (start) begin
        vecQ.push_back(refModel());
        dueQ.push_back(cyc + 1);
      end
    end
    cyc++;
  end

  task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && !finished) begin
      check("R1", "done per clock", 64'(done), 64'(expDone));
      check("R2", "held failVec per clock", 64'(failVec), 64'(expVec));
      check("R2", "pass per clock", 64'(pass), 64'(expVec == 7'd0));
    end
  end

  task automatic setBase();
    cr0Val            = 64'h8000_0021;
    cr0Fixed0         = 64'h8000_0021;
    cr0Fixed1         = 64'hFFFF_FFFF;
    cr4Val            = 64'h2020;
    cr4Fixed0         = 64'h2000;
    cr4Fixed1         = 64'h37_27FF;
    cr3Val            = 64'h1000;
    dbgCtlVal         = 64'd0;
    dbgRsvdMask       = 64'hFFFF_FFFF_FFFF_C03C;
    physAddrWidth     = 8'd40;
    unrestrictedGuest = 1'b0;
    secondaryCtlEn    = 1'b0;
    loadDbgCtl        = 1'b1;
    longModeGuest     = 1'b1;
  endtask

  task automatic runCase(string tag, logic [6:0] expect_);
    logic [6:0] model;
    model = refModel();
    check(tag, "model vs requirement", 64'(model), 64'(expect_));
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    check(tag, "done", 64'(done), 64'd1);
    check(tag, "failVec", 64'(failVec), 64'(expect_));
    check(tag, "pass", 64'(pass), 64'(expect_ == 7'd0));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    setBase();
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11", "done in reset", 64'(done), 64'd0);
    check("R11", "failVec in reset", 64'(failVec), 64'd0);
    check("R11", "pass in reset", 64'(pass), 64'd1);
    rstN = 1'b1;
    @(negedge clk);
    check("R11", "done after reset", 64'(done), 64'd0);

    // R2 clean image
    setBase(); runCase("R2", 7'b0000000);
    // R3 missing forced-one bit, and bit outside the allowed mask
    setBase(); cr0Val[5] = 1'b0; runCase("R3", 7'b0000001);
    setBase(); cr0Val[40] = 1'b1; runCase("R3", 7'b0000001);
    // R3 cache bits never compared
    setBase(); cr0Fixed1[30:29] = 2'b00; cr0Val[30:29] = 2'b11; runCase("R3", 7'b0000000);
    // R4 unrestricted exempts PE/PG only with enable
    setBase(); longModeGuest = 1'b0; cr0Val[31] = 1'b0; cr0Val[0] = 1'b0;
    unrestrictedGuest = 1'b1; secondaryCtlEn = 1'b1; runCase("R4", 7'b0000000);
    secondaryCtlEn = 1'b0; runCase("R4", 7'b0000001);
    // R5 paging without protection even when unrestricted
    setBase(); longModeGuest = 1'b0; cr0Val[0] = 1'b0;
    unrestrictedGuest = 1'b1; secondaryCtlEn = 1'b1; runCase("R5", 7'b0000010);
    // R6 CR4 forced bits
    setBase(); cr4Val[13] = 1'b0; runCase("R6", 7'b0000100);
    setBase(); cr4Val[30] = 1'b1; runCase("R6", 7'b0000100);
    // R7 debug reserved bits
    setBase(); dbgCtlVal = 64'h4; runCase("R7", 7'b0001000);
    setBase(); dbgCtlVal = 64'h4; loadDbgCtl = 1'b0; runCase("R7", 7'b0000000);
    // R8 64-bit prerequisites
    setBase(); cr4Val[5] = 1'b0; runCase("R8", 7'b0010000);
    setBase(); longModeGuest = 1'b0; cr4Val[5] = 1'b0; runCase("R8", 7'b0000000);
    // R9 process-context IDs outside 64-bit mode
    setBase(); longModeGuest = 1'b0; cr4Val[17] = 1'b1; runCase("R9", 7'b0100000);
    setBase(); cr4Val[17] = 1'b1; runCase("R9", 7'b0000000);
    // R10 CR3 width, with clamping at both ends
    setBase(); cr3Val = 64'h1 << 40; runCase("R10", 7'b1000000);
    setBase(); cr3Val = 64'h1 << 40; physAddrWidth = 8'd41; runCase("R10", 7'b0000000);
    setBase(); cr3Val = 64'h1 << 32; physAddrWidth = 8'd20; runCase("R10", 7'b1000000);
    setBase(); cr3Val = 64'h1 << 31; physAddrWidth = 8'd20; runCase("R10", 7'b0000000);
    setBase(); cr3Val = 64'h1 << 51; physAddrWidth = 8'd60; runCase("R10", 7'b0000000);
    setBase(); cr3Val = 64'h1 << 52; physAddrWidth = 8'd60; runCase("R10", 7'b1000000);
    setBase(); cr3Val = 64'h1 << 63; physAddrWidth = 8'd255; runCase("R10", 7'b1000000);

    // R1 back-to-back starts give consecutive verdicts
    setBase(); cr4Val[13] = 1'b0; start = 1'b1;
    @(negedge clk);
    setBase(); dbgCtlVal = 64'h8;
    @(negedge clk);
    start = 1'b0;
    check("R1", "first done", 64'(done), 64'd1);
    check("R1", "first verdict", 64'(failVec), 64'(7'b0000100));
    @(negedge clk);
    check("R1", "second done", 64'(done), 64'd1);
    check("R1", "second verdict", 64'(failVec), 64'(7'b0001000));
    @(negedge clk);
    check("R1", "done drops", 64'(done), 64'd0);
    check("R1", "verdict held", 64'(failVec), 64'(7'b0001000));
    repeat (3) @(negedge clk);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule